// File: doc/BRIEF.md
# Scatter-Gather Table Walker

This block generates DMA addresses for a single command by walking that command's table of region descriptors. A pulse on `start` captures four values: the command table base address, the command header options word, the number of bytes requested, and the header's current transferred-byte count. The walker then reads one descriptor at a time through a request/response port. For each descriptor it issues one burst (address, length) that is no longer than what the descriptor allows and no longer than the bytes still owed. It stops when nothing is owed or when the descriptors run out.

When the walk ends, the block pulses `done` for one cycle. With that pulse it reports the total bytes issued, the updated header byte count, a flag for a command that had no descriptor list, and a flag for a table that ran out before the request was covered. The descriptor port and the burst port both use valid/ready. A request or burst stays valid, with its fields unchanged, until the cycle in which ready is high, and the transfer takes place on that clock edge. The walker has only one descriptor read outstanding at a time. It raises `desc_rsp_ready` only while it waits for that read, so the memory must hold `desc_rsp_valid` and the data until it sees ready.

Top module: `prd_walker`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `desc_req_valid`, `desc_rsp_ready` and `burst_valid` are all low, and `done` is never high for two cycles in a row.
- R2: Descriptor i (counting from 0) is read at address base + 0x80 + 16*i. The reads go in increasing order of i and each descriptor is read only once.
- R3: The descriptor count is `hdr_opts[31:16]`. When it is zero, the block reads no descriptors and issues no bursts. It then gives `done` with `done_nolist`=1, `done_short`=0, total 0, and `hdr_bytes_out` equal to `hdr_bytes_in`.
- R4: A descriptor is 128 bits wide. Bits [127:96] hold a flags/size word, and the entry length is the value of bits [117:96] (22 bits) plus 1. Bits [127:118] and the reserved bits [95:64] have no effect.
- R5: A burst's address is bits [63:0] of the descriptor (low word in [31:0], high word in [63:32]). Its length is the smaller of the entry length and the bytes still remaining. It appears the cycle after the descriptor response is accepted.
- R6: Once the remaining count reaches zero, the block reads no further descriptors and ends with `done_short`=0.
- R7: If every descriptor has been used and bytes are still remaining, the block ends with `done_short`=1.
- R8: `done_total` is the sum of the accepted burst lengths, and `hdr_bytes_out` is `hdr_bytes_in` + `done_total` (modulo 2^32).
- R9: While `burst_valid` is high and `burst_ready` is low, the burst stays valid and its address and length do not change.
- R10: While `desc_req_valid` is high and `desc_req_ready` is low, the request stays valid and its address does not change.
- R11: A `start` pulse, or a change on `tbl_base`, `hdr_opts`, `req_bytes` or `hdr_bytes_in`, while `busy` is high has no effect on the walk in progress.
- R12: When the requested byte count is zero and the table has entries, the block reads no descriptors. It ends with total 0, `done_short`=0 and `done_nolist`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a walk when the block is idle |
| tbl_base | input | 64 | Command table base address |
| hdr_opts | input | 32 | Command header options; [31:16] is the descriptor count |
| req_bytes | input | 32 | Bytes requested for this command |
| hdr_bytes_in | input | 32 | Header byte count before this walk |
| busy | output | 1 | A walk is in progress |
| desc_req_valid | output | 1 | Descriptor read request valid |
| desc_req_ready | input | 1 | Memory accepts the descriptor read |
| desc_req_addr | output | 64 | Byte address of the descriptor |
| desc_rsp_valid | input | 1 | Descriptor data valid |
| desc_rsp_ready | output | 1 | Walker is waiting for descriptor data |
| desc_rsp_data | input | 128 | Descriptor contents |
| burst_valid | output | 1 | Burst request valid |
| burst_ready | input | 1 | Data mover accepts the burst |
| burst_addr | output | 64 | Burst start address |
| burst_len | output | 32 | Burst length in bytes |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_total | output | 32 | Bytes issued over the walk |
| done_nolist | output | 1 | The command had no descriptors (valid with done) |
| done_short | output | 1 | Descriptors ran out before the request was covered (valid with done) |
| hdr_bytes_out | output | 32 | Updated header byte count |

## Verification
Every result has a fixed latency, and the bench checks each one in exactly that cycle:
- The first descriptor request is valid two cycles after the cycle in which `start` is accepted.
- Each later request is valid two cycles after the previous burst is accepted.
- A burst is valid in the cycle after its descriptor response is accepted.
- `done` is high two cycles after the accepting cycle of either the start or the last burst.

A behavioural model in the bench turns each stimulus into queues of expected descriptor addresses and bursts. On every clock it compares the ports against the front of those queues and against these latencies. Runs with throttled ready signals check that held requests and bursts stay stable across back-pressure.

// File: rtl/prdw_pkg.sv
package prdw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STEP,
    ST_FETCH,
    ST_WAIT,
    ST_BURST,
    ST_DONE
  } walk_st_t;

endpackage

// File: rtl/prdw_slot_addr.sv
module prdw_slot_addr #(
  parameter int ADDR_W    = 64,
  parameter int CNT_W     = 16,
  parameter int TBL_OFS   = 128,
  parameter int ENT_BYTES = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int ENT_SHIFT = $clog2(ENT_BYTES);

  assign addr_o = base_i + ADDR_W'(TBL_OFS) + (ADDR_W'(idx_i) << ENT_SHIFT);
endmodule

// File: rtl/prdw_desc_decode.sv
module prdw_desc_decode #(
  parameter int ADDR_W = 64,
  parameter int DESC_W = 128,
  parameter int SIZE_W = 22,
  parameter int LEN_W  = 32
) (
  input  logic [DESC_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int WORD_LSB = DESC_W - 32;

  logic unused_desc_bits;

  assign addr_o = data_i[ADDR_W-1:0];
  assign len_o  = LEN_W'(data_i[WORD_LSB +: SIZE_W]) + LEN_W'(1);
  assign unused_desc_bits = ^{data_i[DESC_W-1:WORD_LSB+SIZE_W], data_i[WORD_LSB-1:ADDR_W]};
endmodule

// File: rtl/prdw_clip.sv
module prdw_clip #(
  parameter int LEN_W = 32
) (
  input  logic [LEN_W-1:0] entry_len_i,
  input  logic [LEN_W-1:0] remain_i,
  output logic [LEN_W-1:0] len_o
);
  assign len_o = (entry_len_i < remain_i) ? entry_len_i : remain_i;
endmodule

// File: rtl/prd_walker.sv
module prd_walker
  import prdw_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LEN_W     = 32,
  parameter int OPT_W     = 32,
  parameter int CNT_W     = 16,
  parameter int SIZE_W    = 22,
  parameter int TBL_OFS   = 128,
  parameter int ENT_BYTES = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       tbl_base,
  input  logic [OPT_W-1:0]        hdr_opts,
  input  logic [LEN_W-1:0]        req_bytes,
  input  logic [LEN_W-1:0]        hdr_bytes_in,
  output logic                    busy,
  output logic                    desc_req_valid,
  input  logic                    desc_req_ready,
  output logic [ADDR_W-1:0]       desc_req_addr,
  input  logic                    desc_rsp_valid,
  output logic                    desc_rsp_ready,
  input  logic [ENT_BYTES*8-1:0]  desc_rsp_data,
  output logic                    burst_valid,
  input  logic                    burst_ready,
  output logic [ADDR_W-1:0]       burst_addr,
  output logic [LEN_W-1:0]        burst_len,
  output logic                    done,
  output logic [LEN_W-1:0]        done_total,
  output logic                    done_nolist,
  output logic                    done_short,
  output logic [LEN_W-1:0]        hdr_bytes_out
);
  localparam int DESC_W = ENT_BYTES * 8;

  walk_st_t            st_q;
  logic [ADDR_W-1:0]   base_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    idx_q;
  logic [LEN_W-1:0]    rem_q;
  logic [LEN_W-1:0]    tot_q;
  logic [LEN_W-1:0]    hdr_q;
  logic [ADDR_W-1:0]   baddr_q;
  logic [LEN_W-1:0]    blen_q;
  logic                nolist_q;
  logic                short_q;

  logic [ADDR_W-1:0]   dec_addr;
  logic [LEN_W-1:0]    dec_len;
  logic [LEN_W-1:0]    clip_len;
  logic                unused_opts;

  assign unused_opts = ^hdr_opts[OPT_W-CNT_W-1:0];

  prdw_slot_addr #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TBL_OFS(TBL_OFS), .ENT_BYTES(ENT_BYTES)
  ) u_slot (
    .base_i(base_q), .idx_i(idx_q), .addr_o(desc_req_addr)
  );

  prdw_desc_decode #(
    .ADDR_W(ADDR_W), .DESC_W(DESC_W), .SIZE_W(SIZE_W), .LEN_W(LEN_W)
  ) u_dec (
    .data_i(desc_rsp_data), .addr_o(dec_addr), .len_o(dec_len)
  );

  prdw_clip #(.LEN_W(LEN_W)) u_clip (
    .entry_len_i(dec_len), .remain_i(rem_q), .len_o(clip_len)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      rem_q    <= '0;
      tot_q    <= '0;
      hdr_q    <= '0;
      baddr_q  <= '0;
      blen_q   <= '0;
      nolist_q <= 1'b0;
      short_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            base_q <= tbl_base;
            cnt_q  <= hdr_opts[OPT_W-1 -: CNT_W];
            idx_q  <= '0;
            rem_q  <= req_bytes;
            tot_q  <= '0;
            hdr_q  <= hdr_bytes_in;
            st_q   <= ST_STEP;
          end
        end
        ST_STEP: begin
          nolist_q <= (cnt_q == '0);
          short_q  <= 1'b0;
          if (cnt_q == '0 || rem_q == '0) begin
            st_q <= ST_DONE;
          end else if (idx_q == cnt_q) begin
            short_q <= 1'b1;
            st_q    <= ST_DONE;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (desc_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (desc_rsp_valid) begin
            baddr_q <= dec_addr;
            blen_q  <= clip_len;
            st_q    <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (burst_ready) begin
            rem_q <= rem_q - blen_q;
            tot_q <= tot_q + blen_q;
            idx_q <= idx_q + CNT_W'(1);
            st_q  <= ST_STEP;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (st_q != ST_IDLE);
  assign desc_req_valid = (st_q == ST_FETCH);
  assign desc_rsp_ready = (st_q == ST_WAIT);
  assign burst_valid    = (st_q == ST_BURST);
  assign burst_addr     = baddr_q;
  assign burst_len      = blen_q;
  assign done           = (st_q == ST_DONE);
  assign done_total     = tot_q;
  assign done_nolist    = done & nolist_q;
  assign done_short     = done & short_q;
  assign hdr_bytes_out  = hdr_q + tot_q;

  // R1: done is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: a stalled burst keeps its fields
  p_burst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr) && $stable(burst_len));

  // R10: a stalled descriptor request keeps its address
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    desc_req_valid && !desc_req_ready |=> desc_req_valid && $stable(desc_req_addr));

  // R3: an empty list moves nothing
  p_nolist_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_nolist |-> (done_total == '0) && !done_short);

  // R5: a burst never exceeds what is still owed
  p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (burst_len != '0) && (burst_len <= rem_q));

  // R8: bytes are moved from remaining to total, none lost
  p_conserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid && burst_ready |=> (rem_q + tot_q) == $past(rem_q + tot_q));

  // R7: short end only with bytes still owed
  p_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_short |-> (rem_q != '0));

  // R11: captured command is left alone while busy
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(base_q) && $stable(hdr_q) && $stable(cnt_q));
endmodule

// File: tb/test_prd_walker.sv
module test_prd_walker;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [63:0]  tbl_base = '0;
  logic [31:0]  hdr_opts = '0;
  logic [31:0]  req_bytes = '0;
  logic [31:0]  hdr_bytes_in = '0;
  logic         busy;
  logic         desc_req_valid;
  logic         desc_req_ready = 1'b0;
  logic [63:0]  desc_req_addr;
  logic         desc_rsp_valid = 1'b0;
  logic         desc_rsp_ready;
  logic [127:0] desc_rsp_data = '0;
  logic         burst_valid;
  logic         burst_ready = 1'b0;
  logic [63:0]  burst_addr;
  logic [31:0]  burst_len;
  logic         done;
  logic [31:0]  done_total;
  logic         done_nolist;
  logic         done_short;
  logic [31:0]  hdr_bytes_out;

  prd_walker i_prd_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_base(tbl_base),
    .hdr_opts(hdr_opts), .req_bytes(req_bytes), .hdr_bytes_in(hdr_bytes_in),
    .busy(busy), .desc_req_valid(desc_req_valid), .desc_req_ready(desc_req_ready),
    .desc_req_addr(desc_req_addr), .desc_rsp_valid(desc_rsp_valid),
    .desc_rsp_ready(desc_rsp_ready), .desc_rsp_data(desc_rsp_data),
    .burst_valid(burst_valid), .burst_ready(burst_ready), .burst_addr(burst_addr),
    .burst_len(burst_len), .done(done), .done_total(done_total),
    .done_nolist(done_nolist), .done_short(done_short), .hdr_bytes_out(hdr_bytes_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // descriptor table held by the bench
  logic [63:0] ent_addr [16];
  logic [31:0] ent_word [16];

  // reference model state
  logic [63:0] exp_desc_q [$];
  logic [63:0] exp_baddr_q [$];
  logic [31:0] exp_blen_q [$];
  logic [31:0] exp_total;
  logic [31:0] exp_hdr;
  bit          exp_short;
  bit          exp_nolist;
  logic [63:0] cur_base;
  bit          expect_active = 0;
  bit          done_seen = 0;
  bit          bp_mode = 0;

  int cyc = 0;
  int last_evt = 0;
  int rsp_cyc = 0;
  bit rsp_next = 0;
  logic [127:0] rsp_next_data = '0;
  bit rsp_clear = 0;
  bit prev_bv = 0, prev_br = 0, prev_rv = 0, prev_rr = 0;
  logic [63:0] prev_baddr = '0, prev_raddr = '0;
  logic [31:0] prev_blen = '0;

  function automatic void build_model(input logic [63:0] base, input int count,
                                      input logic [31:0] req, input logic [31:0] hdr);
    logic [31:0] rem;
    logic [31:0] elen;
    logic [31:0] blen;
    exp_desc_q.delete();
    exp_baddr_q.delete();
    exp_blen_q.delete();
    rem = req;
    exp_total = 0;
    for (int i = 0; i < count && rem != 0; i++) begin
      elen = (ent_word[i] & 32'h003F_FFFF) + 1;
      blen = (elen < rem) ? elen : rem;
      exp_desc_q.push_back(base + 64'h80 + 64'(i) * 16);
      exp_baddr_q.push_back(ent_addr[i]);
      exp_blen_q.push_back(blen);
      rem = rem - blen;
      exp_total = exp_total + blen;
    end
    exp_nolist = (count == 0);
    exp_short  = (count != 0) && (rem != 0);
    exp_hdr    = hdr + exp_total;
    cur_base   = base;
  endfunction

  // input driver and per-clock comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_clear) begin
        desc_rsp_valid = 1'b0;
        rsp_clear = 0;
      end
      if (rsp_next) begin
        desc_rsp_valid = 1'b1;
        desc_rsp_data  = rsp_next_data;
        rsp_next = 0;
      end
      desc_req_ready = bp_mode ? ((cyc % 2) == 1) : 1'b1;
      burst_ready    = bp_mode ? ((cyc % 3) != 0) : 1'b1;
      #1;
      cyc++;
      if (rst_n) begin
        if (start && !busy) last_evt = cyc;
        // descriptor requests: R2, R10, R6
        if (desc_req_valid) begin
          if (!(prev_rv && !prev_rr)) begin
            chk(cyc == last_evt + 2, "R2 request latency", 64'(cyc), 64'(last_evt + 2));
          end else begin
            chk(desc_req_addr == prev_raddr, "R10 held request address", desc_req_addr, prev_raddr);
          end
          if (desc_req_ready) begin
            if (exp_desc_q.size() == 0) begin
              chk(0, "R6 unexpected descriptor read", desc_req_addr, 64'h0);
            end else begin
              chk(desc_req_addr == exp_desc_q[0], "R2 descriptor address", desc_req_addr, exp_desc_q[0]);
              begin
                logic [63:0] off;
                int k;
                off = desc_req_addr - cur_base - 64'h80;
                k = int'(off >> 4);
                if (k < 0 || k > 15) k = 0;
                rsp_next_data = {ent_word[k], 32'hA5A5_5A5A, ent_addr[k]};
              end
              void'(exp_desc_q.pop_front());
              rsp_next = 1;
            end
          end
        end else if (prev_rv && !prev_rr) begin
          chk(0, "R10 request dropped while stalled", 64'h0, 64'h1);
        end
        if (desc_rsp_valid && desc_rsp_ready) begin
          rsp_cyc = cyc;
          rsp_clear = 1;
        end
        // bursts: R5, R9
        if (burst_valid) begin
          if (!(prev_bv && !prev_br)) begin
            chk(cyc == rsp_cyc + 1, "R5 burst latency", 64'(cyc), 64'(rsp_cyc + 1));
          end else begin
            chk(burst_addr == prev_baddr && burst_len == prev_blen, "R9 held burst",
                {burst_len, burst_addr[31:0]}, {prev_blen, prev_baddr[31:0]});
          end
          if (burst_ready) begin
            if (exp_baddr_q.size() == 0) begin
              chk(0, "R6 unexpected burst", burst_addr, 64'h0);
            end else begin
              chk(burst_addr == exp_baddr_q[0], "R5 burst address", burst_addr, exp_baddr_q[0]);
              chk(burst_len == exp_blen_q[0], "R5 burst length", 64'(burst_len), 64'(exp_blen_q[0]));
              void'(exp_baddr_q.pop_front());
              void'(exp_blen_q.pop_front());
            end
            last_evt = cyc;
          end
        end else if (prev_bv && !prev_br) begin
          chk(0, "R9 burst dropped while stalled", 64'h0, 64'h1);
        end
        // completion: R3, R6, R7, R8, R12
        if (done) begin
          if (!expect_active || done_seen) begin
            chk(0, "R1 unexpected done", 64'h1, 64'h0);
          end else begin
            chk(cyc == last_evt + 2, "R8 done latency", 64'(cyc), 64'(last_evt + 2));
            chk(done_total == exp_total, "R8 done_total", 64'(done_total), 64'(exp_total));
            chk(hdr_bytes_out == exp_hdr, "R8 hdr_bytes_out", 64'(hdr_bytes_out), 64'(exp_hdr));
            chk(done_short == exp_short, "R7 done_short", 64'(done_short), 64'(exp_short));
            chk(done_nolist == exp_nolist, "R3 done_nolist", 64'(done_nolist), 64'(exp_nolist));
            chk(exp_baddr_q.size() == 0 && exp_desc_q.size() == 0, "R6 bursts outstanding at done",
                64'(exp_baddr_q.size()), 64'h0);
            done_seen = 1;
          end
        end
      end
      prev_bv = burst_valid; prev_br = burst_ready;
      prev_baddr = burst_addr; prev_blen = burst_len;
      prev_rv = desc_req_valid; prev_rr = desc_req_ready; prev_raddr = desc_req_addr;
    end
  end

  task automatic kick(input logic [63:0] base, input int count, input logic [31:0] req,
                      input logic [31:0] hdr);
    build_model(base, count, req, hdr);
    done_seen = 0;
    expect_active = 1;
    @(negedge clk);
    tbl_base     = base;
    hdr_opts     = {16'(count), 16'h5A3C};
    req_bytes    = req;
    hdr_bytes_in = hdr;
    start        = 1'b1;
    @(negedge clk);
    start        = 1'b0;
  endtask

  task automatic finish_walk(input string tag);
    int waited = 0;
    while (!done_seen && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_seen, tag, 64'(done_seen), 64'h1);
    expect_active = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      ent_addr[i] = 64'h0000_0012_0000_0000 + 64'(i) * 64'h1_0000;
      ent_word[i] = 32'h0000_00FF;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    chk(!busy && !done && !desc_req_valid && !burst_valid && !desc_rsp_ready,
        "R1 idle after reset", {59'h0, busy, done, desc_req_valid, burst_valid, desc_rsp_ready}, 64'h0);

    // R4/R5/R6: flag bits set, request ends partway into entry 1
    ent_word[0] = 32'h8000_00FF;
    ent_word[1] = 32'h0040_01FF;
    ent_word[2] = 32'hFFC0_03FF;
    kick(64'h0000_0001_0000_1000, 3, 32'd600, 32'd40);
    finish_walk("R6 walk ends on zero remaining");

    // R7: entries exhausted with bytes owed
    ent_word[0] = 32'd99;
    ent_word[1] = 32'd199;
    kick(64'h0000_0000_2000_0000, 2, 32'd1000, 32'hFFFF_FF00);
    finish_walk("R7 short walk completes");

    // R3: empty list
    kick(64'h0000_0000_3000_0000, 0, 32'd500, 32'd7);
    finish_walk("R3 empty list completes");

    // R12: zero request with entries
    kick(64'h0000_0000_4000_0000, 3, 32'd0, 32'd9);
    finish_walk("R12 zero request completes");

    // R9/R10: back-pressure, request exactly covered by 4 entries
    bp_mode = 1;
    ent_word[0] = 32'd15;
    ent_word[1] = 32'd31;
    ent_word[2] = 32'd63;
    ent_word[3] = 32'd127;
    kick(64'h0000_0000_5000_0040, 4, 32'd240, 32'd0);
    finish_walk("R9 back-pressured walk completes");
    bp_mode = 0;

    // R11: start and input changes while busy are ignored
    ent_word[0] = 32'h0000_00FF;
    ent_word[1] = 32'h0000_00FF;
    kick(64'h0000_0000_6000_0000, 2, 32'd300, 32'd100);
    @(negedge clk);
    tbl_base = 64'h0000_0000_7777_0000;
    hdr_opts = 32'h0000_0000;
    req_bytes = 32'd5;
    hdr_bytes_in = 32'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_walk("R11 walk unaffected by busy start");

    // R4: full-width size field and flags-only size
    ent_word[0] = 32'h003F_FFFF;
    ent_word[1] = 32'hFFC0_0000;
    kick(64'h0000_0000_8000_0000, 2, 32'h0050_0000, 32'd0);
    finish_walk("R4 size field decode");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule